// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This block connects a plain synchronous request port to a one-bit-wide dynamic cell array whose address pins are shared between row and column. A full address of ROW_W + COL_W bits is accepted in one handshake. It is then sent to the array over a MUX_W-bit bus in two steps. The row half goes out first under a row strobe. The column half follows under a column strobe, with the write select and write bit. Read data comes back from the array one cycle after the column step, and the block presents it on the response port.

The block also keeps the stored charge alive. An interval counter, whose period is set by an input, raises a refresh request. When the sequencer is idle it serves that request ahead of any new access. It runs a row-only cycle on the row named by an internal pointer, and the array reads and restores that row during the cycle. The pointer then steps to the next row and wraps back to zero after the last row. For the whole refresh cycle the request port shows not-ready. Accesses are therefore held off, and throughput drops by the time spent refreshing.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and mem_ras, mem_cas, mem_we and rsp_valid are 0.
- R2: A request is taken on a cycle with req_valid and req_ready both 1. In the next cycle mem_ras is 1, mem_cas is 0 and mem_addr carries the upper ROW_W address bits (the row). In the cycle after that, mem_ras and mem_cas are both 1 and mem_addr carries the lower COL_W bits (the column).
- R3: mem_we is 1 only during the column cycle of a write, and mem_wdata then carries the request's write bit. During the column cycle of a read, mem_we is 0.
- R4: rsp_valid is 1 for exactly the one cycle that follows the column cycle. For a read, rsp_rdata then equals mem_rdata. req_ready stays 0 from the cycle after acceptance through the response cycle.
- R5: With cfg_ref_ivl = N > 0 and no traffic, successive refresh cycles start N cycles apart. With cfg_ref_ivl = 0, no refresh starts.
- R6: A refresh cycle holds mem_ras at 1 for exactly two cycles, with mem_addr set to the refresh row. mem_cas and mem_we stay 0, and req_ready is 0 throughout.
- R7: The refresh row is 0 for the first refresh after reset. It rises by one with each refresh and wraps from 2^ROW_W-1 to 0.
- R8: A refresh that falls due during an access waits until that access has finished. It then runs before a request that is already waiting. req_ready is 0 in the idle cycle between the access and the refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ref_ivl | input | IVL_W | Refresh period in cycles; 0 disables refresh |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Full address: row in upper bits, column in lower bits |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | Access completed this cycle |
| rsp_rdata | output | 1 | Read result (0 for writes) |
| mem_addr | output | MUX_W | Shared row/column address bus to the array |
| mem_ras | output | 1 | Row strobe, active high |
| mem_cas | output | 1 | Column strobe, active high |
| mem_we | output | 1 | Write select, valid in the column cycle |
| mem_wdata | output | 1 | Write bit to the array |
| mem_rdata | input | 1 | Read bit from the array, valid the cycle after the column cycle |

## Verification
The bench builds the block with a 4-bit row and a 4-bit column and an 8-bit interval field. This keeps a full behavioural array of 256 bits inside the bench, so every written bit can be read back. It also lets the row pointer go round all 16 rows and wrap within a few hundred cycles. Refresh periods of 5 and 6 cycles are short enough that a refresh request can be made to land in the middle of an access. That exposes the ordering between refresh and a waiting request.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ROW   = 3'd1,
    ST_COL   = 3'd2,
    ST_RSP   = 3'd3,
    ST_RROW  = 3'd4,
    ST_RHOLD = 3'd5,
    ST_REND  = 3'd6
  } dmx_state_e;

  // Step a counter by one, going back to zero after the last value.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned last);
    return (v >= last) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/dmx_ref_timer.sv
module dmx_ref_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IVL_W-1:0] ivl,
  input  logic             clear,
  output logic             pend
);
  logic [IVL_W-1:0] cnt;
  logic             tick;

  assign tick = (ivl != '0) && (cnt >= ivl - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (ivl == '0) cnt <= '0;
      else if (tick) cnt <= '0;
      else cnt <= cnt + 1'b1;
      if (clear) pend <= 1'b0;
      if (tick) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/dmx_row_ptr.sv
module dmx_row_ptr import dmx_pkg::*; #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  localparam int unsigned LAST = (1 << ROW_W) - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) row <= '0;
    else if (step) row <= ROW_W'(wrap_inc(int'(row), LAST));
  end
endmodule

// File: rtl/dmx_fsm.sv
module dmx_fsm import dmx_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       ref_pend,
  output dmx_state_e state
);
  dmx_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (ref_pend) nxt = ST_RROW;
        else if (req_valid) nxt = ST_ROW;
      end
      ST_ROW:   nxt = ST_COL;
      ST_COL:   nxt = ST_RSP;
      ST_RSP:   nxt = ST_IDLE;
      ST_RROW:  nxt = ST_RHOLD;
      ST_RHOLD: nxt = ST_REND;
      ST_REND:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else state <= nxt;
  end
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl import dmx_pkg::*; #(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int IVL_W = 16,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVL_W-1:0]  cfg_ref_ivl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic [MUX_W-1:0]  mem_addr,
  output logic              mem_ras,
  output logic              mem_cas,
  output logic              mem_we,
  output logic              mem_wdata,
  input  logic              mem_rdata
);
  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  dmx_state_e       state;
  logic             ref_pend;
  logic             ref_done;
  logic             ref_active;
  logic             acc_accept;
  logic [ROW_W-1:0] ref_row;
  logic [ROW_W-1:0] lat_row;
  logic [COL_W-1:0] lat_col;
  logic             lat_we;
  logic             lat_d;

  assign req_ready  = (state == ST_IDLE) && !ref_pend;
  assign acc_accept = req_valid && req_ready;
  assign ref_done   = (state == ST_REND);
  assign ref_active = (state == ST_RROW) || (state == ST_RHOLD) || (state == ST_REND);

  dmx_ref_timer #(.IVL_W(IVL_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .ivl   (cfg_ref_ivl),
    .clear (ref_done),
    .pend  (ref_pend)
  );

  dmx_row_ptr #(.ROW_W(ROW_W)) u_rowptr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (ref_done),
    .row   (ref_row)
  );

  dmx_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ref_pend  (ref_pend),
    .state     (state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_row <= '0;
      lat_col <= '0;
      lat_we  <= 1'b0;
      lat_d   <= 1'b0;
    end else if (acc_accept) begin
      lat_row <= row_of(req_addr);
      lat_col <= col_of(req_addr);
      lat_we  <= req_write;
      lat_d   <= req_wdata;
    end
  end

  always_comb begin
    case (state)
      ST_ROW:            mem_addr = MUX_W'(lat_row);
      ST_COL:            mem_addr = MUX_W'(lat_col);
      ST_RROW, ST_RHOLD: mem_addr = MUX_W'(ref_row);
      default:           mem_addr = '0;
    endcase
  end

  assign mem_ras   = (state == ST_ROW) || (state == ST_COL) ||
                     (state == ST_RROW) || (state == ST_RHOLD);
  assign mem_cas   = (state == ST_COL);
  assign mem_we    = (state == ST_COL) && lat_we;
  assign mem_wdata = (state == ST_COL) && lat_we && lat_d;
  assign rsp_valid = (state == ST_RSP);
  assign rsp_rdata = (state == ST_RSP) && !lat_we && mem_rdata;
endmodule

// File: rtl/dmx_checker.sv
module dmx_checker import dmx_pkg::*; #(
  parameter int ROW_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             mem_ras,
  input logic             mem_cas,
  input logic             mem_we,
  input logic             ref_active,
  input logic             ref_done,
  input logic [ROW_W-1:0] ref_row
);
  localparam int unsigned LAST = (1 << ROW_W) - 1;

  a_r2_cas_needs_ras: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cas |-> mem_ras);

  a_r2_row_before_col: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cas) |-> ($past(mem_ras) && !$past(mem_cas)));

  a_r3_we_in_col: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_cas);

  a_r4_rsp_after_col: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(mem_cas) && !mem_ras));

  a_r6_ready_low_ref: assert property (@(posedge clk) disable iff (!rst_n)
    ref_active |-> !req_ready);

  a_r6_no_cas_ref: assert property (@(posedge clk) disable iff (!rst_n)
    ref_active |-> (!mem_cas && !mem_we));

  a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> (ref_row == ROW_W'(wrap_inc(int'($past(ref_row)), LAST))));

  a_r8_ref_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_active) |-> !$past(mem_ras));
endmodule

bind dram_mux_ctrl dmx_checker #(.ROW_W(ROW_W)) u_dmx_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_ras    (mem_ras),
  .mem_cas    (mem_cas),
  .mem_we     (mem_we),
  .ref_active (ref_active),
  .ref_done   (ref_done),
  .ref_row    (ref_row)
);

// File: tb/tb_dram_mux_ctrl.sv
module tb_dram_mux_ctrl;
  localparam int RW = 4;
  localparam int CW = 4;
  localparam int IW = 8;
  localparam int NROW = 1 << RW;
  localparam int NBIT = 1 << (RW + CW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] cfg_ref_ivl = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [RW+CW-1:0] req_addr = '0;
  logic          req_wdata = 1'b0;
  logic          rsp_valid, rsp_rdata;
  logic [RW-1:0] mem_addr;
  logic          mem_ras, mem_cas, mem_we, mem_wdata;
  logic          mem_rdata = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dram_mux_ctrl #(.ROW_W(RW), .COL_W(CW), .IVL_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_ref_ivl(cfg_ref_ivl),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ras(mem_ras), .mem_cas(mem_cas),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural cell array: latches row on strobe, acts in column cycle.
  logic          cells [NBIT];
  logic          shadow [NBIT];
  logic [RW-1:0] arr_row;
  logic          ras_q = 1'b0;
  always @(posedge clk) begin
    ras_q <= mem_ras;
    if (mem_ras && !ras_q) arr_row <= mem_addr;
    if (mem_ras && mem_cas) begin
      if (mem_we) cells[{arr_row, mem_addr}] <= mem_wdata;
      else mem_rdata <= cells[{arr_row, mem_addr}];
    end
  end

  // Refresh monitor, sampled at the falling edge.
  int  cyc = 0;
  int  ref_n = 0;
  int  rise_cyc = 0;
  int  last_start = 0;
  int  hi_len = 0;
  bit  fresh = 0;
  bit  is_ref = 0;
  bit  spacing_on = 0;
  logic          mon_ras = 1'b0;
  logic [RW-1:0] rise_addr = '0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_ras && !mon_ras) begin
        rise_addr = mem_addr; rise_cyc = cyc; hi_len = 1; fresh = 1;
      end else if (mem_ras) begin
        hi_len++;
        if (fresh) begin
          fresh = 0;
          is_ref = !mem_cas;
          if (is_ref) begin
            chk(rise_addr == RW'(ref_n % NROW), "R7 refresh row", rise_addr, ref_n % NROW);
            if (spacing_on)
              chk(rise_cyc - last_start == int'(cfg_ref_ivl), "R5 refresh spacing",
                  rise_cyc - last_start, cfg_ref_ivl);
            last_start = rise_cyc;
            ref_n++;
          end
        end
        if (is_ref && (mem_cas || mem_we || req_ready))
          chk(0, "R6 strobe/ready during refresh", {mem_cas, mem_we, req_ready}, 0);
      end
      if (!mem_ras && mon_ras && is_ref) begin
        chk(hi_len == 2, "R6 row strobe length", hi_len, 2);
        is_ref = 0;
      end
    end
    mon_ras = mem_ras;
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_ras && !mem_cas && !mem_we && !rsp_valid, "R1 reset state",
        {req_ready, mem_ras, mem_cas, mem_we, rsp_valid}, 5'b10000);
  endtask

  task automatic t_access(input bit wr, input logic [RW+CW-1:0] a, input logic d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_ras && !mem_cas && mem_addr == a[RW+CW-1:CW] && !req_ready, "R2 row phase",
        mem_addr, a[RW+CW-1:CW]);
    @(negedge clk);
    chk(mem_ras && mem_cas && mem_addr == a[CW-1:0] && !req_ready, "R2 column phase",
        mem_addr, a[CW-1:0]);
    chk(mem_we == wr && (!wr || mem_wdata == d), "R3 write select",
        {mem_we, mem_wdata}, {wr, wr & d});
    @(negedge clk);
    chk(rsp_valid && !req_ready && !mem_ras, "R4 response cycle", rsp_valid, 1);
    if (!wr) chk(rsp_rdata == shadow[a], "R4 read data", rsp_rdata, shadow[a]);
    else shadow[a] = d;
    @(negedge clk);
    chk(!rsp_valid, "R4 single response", rsp_valid, 0);
  endtask

  task automatic t_data_patterns();
    for (int i = 0; i < NBIT; i++) begin
      cells[i] = 1'b0;
      shadow[i] = 1'b0;
    end
    t_access(1, 8'h00, 1'b1);
    t_access(1, 8'hFF, 1'b1);
    t_access(1, 8'h5A, 1'b1);
    t_access(1, 8'hA5, 1'b0);
    t_access(1, 8'h0F, 1'b1);
    t_access(0, 8'h00, 1'b0);
    t_access(0, 8'hFF, 1'b0);
    t_access(0, 8'h5A, 1'b0);
    t_access(0, 8'hA5, 1'b0);
    t_access(0, 8'hF0, 1'b0);
    t_access(0, 8'h0F, 1'b0);
    t_access(1, 8'h5A, 1'b0);
    t_access(0, 8'h5A, 1'b0);
    @(negedge clk);
    chk(req_ready, "R4 ready returns", req_ready, 1);
  endtask

  task automatic t_refresh_wrap();
    int start;
    cfg_ref_ivl = 8'd5;
    spacing_on = 0;
    start = ref_n;
    while (ref_n == start) @(negedge clk);
    spacing_on = 1;
    start = ref_n;
    while (ref_n < start + NROW + 3) @(negedge clk);
    spacing_on = 0;
    chk(ref_n >= NROW + 3, "R7 wrap reached", ref_n, NROW + 3);
  endtask

  task automatic t_refresh_priority();
    int start;
    logic [RW+CW-1:0] a = 8'hFF;
    cfg_ref_ivl = 8'd6;
    @(negedge clk);
    start = ref_n;
    while (ref_n == start) @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    chk(mem_ras && !mem_cas && mem_addr == a[RW+CW-1:CW], "R8 access starts", mem_addr, a[RW+CW-1:CW]);
    @(negedge clk);
    chk(mem_cas, "R8 access continues", mem_cas, 1);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == shadow[a], "R8 access finishes", rsp_rdata, shadow[a]);
    @(negedge clk);
    chk(!req_ready && !mem_ras, "R8 ready low before refresh", {req_ready, mem_ras}, 0);
    start = ref_n;
    @(negedge clk);
    chk(mem_ras && !mem_cas && mem_addr == RW'(start % NROW), "R8 refresh goes first",
        mem_addr, start % NROW);
    while (!mem_cas) @(negedge clk);
    chk(!mem_we && mem_addr == a[CW-1:0], "R8 held request served after", mem_addr, a[CW-1:0]);
    req_valid = 1'b0;
    cfg_ref_ivl = '0;
  endtask

  task automatic t_refresh_off();
    int start;
    cfg_ref_ivl = '0;
    repeat (20) @(negedge clk);
    start = ref_n;
    repeat (60) @(negedge clk);
    chk(ref_n == start, "R5 refresh disabled", ref_n, start);
    chk(req_ready, "R5 ready while disabled", req_ready, 1);
  endtask

  initial begin
    t_reset();
    t_data_patterns();
    t_refresh_wrap();
    t_refresh_priority();
    t_refresh_off();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule